// File: doc/BRIEF.md
# Data-Ready Sequencer

This block decides when a fresh conversion result is copied into the output register of a converter, and it drives the active-low data-ready strobe that frames host access to that register. A result-valid pulse from the filter starts a fixed-length high phase on the strobe. At the end of that phase the block issues a one-cycle load enable, and the strobe then goes low to invite a host transaction. Once a host transaction completes, the strobe returns high. If no host transaction takes place, the strobe stays low until the next result arrives. A result that arrives while the host is still reading is dropped, so the register keeps the data being read.

The block also owns the conversion-period counter. This counter wraps at the end of each data period and sends a period tick to the filter. An active-low sync input that stays low long enough clears the counter, so that several converters on a common clock can line up their periods. The strobe is held inactive for as long as sync is low. A settling tracker counts the data periods that must pass before the output is trustworthy again: four after an input change, and three after a qualifying sync. All inputs are synchronous to the system clock.

Top module: `drdy_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `drdy_n_o` is 1, `load_en_o` is 0, `period_cnt_o` is 0 and `period_tick_o` is 0.
- R2: `period_cnt_o` counts 0 to PERIOD_CYC-1 and wraps to 0. `period_tick_o` is 1 exactly in the cycles where the count is PERIOD_CYC-1 and no sync clear is taking place.
- R3: The block accepts a `res_valid_i` sample when sync is high, the block is not already in a high phase and `busy_i` is 0. After an accepted sample, `drdy_n_o` is 1 for exactly STROBE_CYC cycles. `load_en_o` is 1 only in the last of those cycles, and `drdy_n_o` is 0 from the next cycle.
- R4: When no result and no transaction occur, `drdy_n_o` stays 0 after a load.
- R5: While the strobe is low, a transaction end (`busy_i` sampled 1 and then sampled 0) makes `drdy_n_o` 1 from the following cycle.
- R6: A `res_valid_i` that arrives while `busy_i` is 1 is discarded. No load enable follows and the strobe does not change.
- R7: A `res_valid_i` that arrives during a high phase is ignored, so only one load results.
- R8: In every cycle where `sync_n_i` is 0, `drdy_n_o` is 1 and `load_en_o` is 0. A sync low during a high phase cancels the pending load.
- R9: When `sync_n_i` is sampled 0 on SYNC_MIN consecutive edges, the counter is 0 after the last of those edges and stays 0 while sync is held low. A shorter low pulse leaves the count running.
- R10: `input_chg_i` sets the settling count to SETTLE_NORMAL. `out_valid_o` is 0 until that many period ticks have passed, and 1 afterwards.
- R11: A qualifying sync sets the settling count to SETTLE_SYNC (3). `out_valid_o` becomes 1 after the third period tick following release.
- R12: Reset loads the settling count with SETTLE_NORMAL, so `out_valid_o` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid_i | input | 1 | Result-valid pulse from the filter |
| busy_i | input | 1 | Host transaction in progress |
| sync_n_i | input | 1 | Active-low sync request |
| input_chg_i | input | 1 | Pulse: analog input selection or gain changed |
| drdy_n_o | output | 1 | Active-low data-ready strobe |
| load_en_o | output | 1 | Load enable for the output register |
| period_tick_o | output | 1 | End-of-period strobe to the filter |
| period_cnt_o | output | CNT_W | Current conversion-period count |
| out_valid_o | output | 1 | Output settled and valid |

## Verification
A result sampled on edge e raises the strobe in the cycle after e. The load enable appears STROBE_CYC cycles later, and the strobe falls one cycle after that. A transaction end is seen one cycle after `busy_i` is sampled low. A sync clear shows a zero count after the SYNC_MIN-th low edge. Sync inhibit and the period tick are combinational and take effect in the same cycle. The bench drives inputs just after a rising edge and samples at the falling edge. On every cycle it compares each output with a behavioural model that was advanced on that rising edge. Its directed checks count whole cycles from the sampling edge, for example 3·PERIOD_CYC+1 falling edges after a sync release before `out_valid_o` must rise.

// File: rtl/drdy_pkg.sv
package drdy_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HOLD  = 2'd1,
      ST_READY = 2'd2
   } strobe_state_t;
endpackage

// File: rtl/drdy_period_ctr.sv
module drdy_period_ctr #(
   parameter int PERIOD_CYC = 1024,
   parameter int SYNC_MIN   = 11,
   localparam int CNT_W     = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_n_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             tick_o,
   output logic             sync_hit_o
);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD_CYC - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             sync_hit;

   generate
      if (SYNC_MIN == 1) begin : g_direct
         assign sync_hit = ~sync_n_i;
      end else begin : g_count
         localparam int LOW_W = $clog2(SYNC_MIN + 1);
         logic [LOW_W-1:0] low_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          low_q <= '0;
            else if (sync_n_i)                   low_q <= '0;
            else if (low_q != LOW_W'(SYNC_MIN))  low_q <= low_q + 1'b1;
         end
         assign sync_hit = ~sync_n_i && (low_q >= LOW_W'(SYNC_MIN - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (sync_hit)         cnt_q <= '0;
      else if (cnt_q == CNT_LAST) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o      = cnt_q;
   assign tick_o     = (cnt_q == CNT_LAST) && !sync_hit;
   assign sync_hit_o = sync_hit;

   // R9
   sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_hit_o |=> (cnt_o == '0));
   // R2
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (cnt_o == '0));
   // R2
   range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= CNT_LAST);
endmodule

// File: rtl/drdy_strobe_fsm.sv
module drdy_strobe_fsm
   import drdy_pkg::*;
#(
   parameter int STROBE_CYC = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic res_valid_i,
   input  logic busy_i,
   input  logic sync_n_i,
   output logic drdy_n_o,
   output logic load_en_o
);
   localparam int HOLD_W = $clog2(STROBE_CYC);
   localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(STROBE_CYC - 1);

   strobe_state_t    state_q;
   logic [HOLD_W-1:0] hold_q;
   logic             busy_q;
   logic             xact_end;

   assign xact_end = busy_q && !busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         hold_q  <= '0;
         busy_q  <= 1'b0;
      end else begin
         busy_q <= busy_i;
         if (!sync_n_i) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
         end else begin
            case (state_q)
               ST_HOLD: begin
                  if (hold_q == HOLD_LAST) begin
                     state_q <= ST_READY;
                     hold_q  <= '0;
                  end else begin
                     hold_q <= hold_q + 1'b1;
                  end
               end
               ST_READY: begin
                  if (res_valid_i && !busy_i) begin
                     state_q <= ST_HOLD;
                     hold_q  <= '0;
                  end else if (xact_end) begin
                     state_q <= ST_IDLE;
                  end
               end
               default: begin
                  if (res_valid_i && !busy_i) begin
                     state_q <= ST_HOLD;
                     hold_q  <= '0;
                  end
               end
            endcase
         end
      end
   end

   always_comb begin
      load_en_o = (state_q == ST_HOLD) && (hold_q == HOLD_LAST) && sync_n_i;
      drdy_n_o  = (state_q != ST_READY) || !sync_n_i;
   end

   // R3
   load_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_en_o |=> (state_q == ST_READY));
   // R3
   fall_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drdy_n_o) |-> $past(load_en_o));
   // R6
   discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READY && res_valid_i && busy_i && sync_n_i) |=> (state_q == ST_READY));
   // R8
   sync_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_n_i |=> (state_q == ST_IDLE));
endmodule

// File: rtl/drdy_settle_trk.sv
module drdy_settle_trk #(
   parameter int SETTLE_NORMAL = 4,
   parameter int SETTLE_SYNC   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic input_chg_i,
   input  logic sync_hit_i,
   input  logic tick_i,
   output logic valid_o
);
   localparam int SW = $clog2(SETTLE_NORMAL + 1);
   localparam logic [SW-1:0] LD_NORMAL = SW'(SETTLE_NORMAL);
   localparam logic [SW-1:0] LD_SYNC   = SW'(SETTLE_SYNC);

   logic [SW-1:0] settle_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       settle_q <= LD_NORMAL;
      else if (sync_hit_i)              settle_q <= LD_SYNC;
      else if (input_chg_i)             settle_q <= LD_NORMAL;
      else if (tick_i && settle_q != '0) settle_q <= settle_q - 1'b1;
   end

   assign valid_o = (settle_q == '0);

   // R11
   sync_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_hit_i |=> (settle_q == LD_SYNC));
   // R10
   chg_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (input_chg_i && !sync_hit_i) |=> (settle_q == LD_NORMAL));
   // R10
   hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !input_chg_i && !sync_hit_i) |=> valid_o);
endmodule

// File: rtl/drdy_seq.sv
module drdy_seq #(
   parameter int PERIOD_CYC    = 1024,
   parameter int STROBE_CYC    = 12,
   parameter int SYNC_MIN      = 11,
   parameter int SETTLE_NORMAL = 4,
   parameter int SETTLE_SYNC   = 3,
   localparam int CNT_W        = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             res_valid_i,
   input  logic             busy_i,
   input  logic             sync_n_i,
   input  logic             input_chg_i,
   output logic             drdy_n_o,
   output logic             load_en_o,
   output logic             period_tick_o,
   output logic [CNT_W-1:0] period_cnt_o,
   output logic             out_valid_o
);
   generate
      if (STROBE_CYC < 2) begin : g_bad_strobe
         $error("STROBE_CYC must be at least 2");
      end
      if (PERIOD_CYC < 2 * STROBE_CYC) begin : g_bad_period
         $error("PERIOD_CYC must cover two strobe phases");
      end
      if (SYNC_MIN < 1) begin : g_bad_sync
         $error("SYNC_MIN must be at least 1");
      end
      if (SETTLE_SYNC < 1 || SETTLE_SYNC > SETTLE_NORMAL) begin : g_bad_settle
         $error("SETTLE_SYNC must lie in 1..SETTLE_NORMAL");
      end
   endgenerate

   logic sync_hit;
   logic tick;

   drdy_period_ctr #(
      .PERIOD_CYC (PERIOD_CYC),
      .SYNC_MIN   (SYNC_MIN)
   ) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_n_i   (sync_n_i),
      .cnt_o      (period_cnt_o),
      .tick_o     (tick),
      .sync_hit_o (sync_hit)
   );

   drdy_strobe_fsm #(
      .STROBE_CYC (STROBE_CYC)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .res_valid_i (res_valid_i),
      .busy_i      (busy_i),
      .sync_n_i    (sync_n_i),
      .drdy_n_o    (drdy_n_o),
      .load_en_o   (load_en_o)
   );

   drdy_settle_trk #(
      .SETTLE_NORMAL (SETTLE_NORMAL),
      .SETTLE_SYNC   (SETTLE_SYNC)
   ) u_settle (
      .clk         (clk),
      .rst_n       (rst_n),
      .input_chg_i (input_chg_i),
      .sync_hit_i  (sync_hit),
      .tick_i      (tick),
      .valid_o     (out_valid_o)
   );

   assign period_tick_o = tick;

   // R8
   sync_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_n_i |-> (drdy_n_o && !load_en_o));
endmodule

// File: tb/sim_drdy_seq.sv
module sim_drdy_seq;
   localparam int P   = 40;
   localparam int S   = 12;
   localparam int SYN = 11;
   localparam int SN  = 4;
   localparam int SS  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic res_valid = 1'b0, busy = 1'b0, sync_n = 1'b1, chg = 1'b0;
   logic drdy_n, load_en, tick, valid;
   logic [5:0] cnt;

   int n_chk = 0, n_fail = 0, cyc = 0, n_load = 0;
   bit cmp_on = 1'b0, done = 1'b0;

   // behavioural model state: 0 idle, 1 high phase, 2 ready
   int m_cnt = 0, m_low = 0, m_state = 0, m_hold = 0, m_settle = SN;
   bit m_busy_q = 1'b0;

   always #4 clk = ~clk;

   drdy_seq #(.PERIOD_CYC(P), .STROBE_CYC(S), .SYNC_MIN(SYN),
              .SETTLE_NORMAL(SN), .SETTLE_SYNC(SS)) u0 (
      .clk(clk), .rst_n(rst_n), .res_valid_i(res_valid), .busy_i(busy),
      .sync_n_i(sync_n), .input_chg_i(chg), .drdy_n_o(drdy_n),
      .load_en_o(load_en), .period_tick_o(tick), .period_cnt_o(cnt),
      .out_valid_o(valid));

   task automatic chk(input int act, input int exp, input string req);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d time=%0t", req, act, exp, $time);
      end
   endtask

   // model advance on each rising edge
   always @(posedge clk) begin
      bit u_hit, u_tick;
      if (!rst_n) begin
         m_cnt = 0; m_low = 0; m_state = 0; m_hold = 0; m_settle = SN; m_busy_q = 0;
      end else begin
         u_hit  = !sync_n && (m_low >= SYN - 1);
         u_tick = (m_cnt == P - 1) && !u_hit;
         m_low  = sync_n ? 0 : ((m_low < SYN) ? m_low + 1 : SYN);
         m_cnt  = u_hit ? 0 : (m_cnt + 1) % P;
         if (!sync_n) begin
            m_state = 0; m_hold = 0;
         end else if (m_state == 1) begin
            if (m_hold == S - 1) begin m_state = 2; m_hold = 0; end
            else m_hold++;
         end else if (res_valid && !busy) begin
            m_state = 1; m_hold = 0;
         end else if (m_state == 2 && m_busy_q && !busy) begin
            m_state = 0;
         end
         m_busy_q = busy;
         if (u_hit)                       m_settle = SS;
         else if (chg)                    m_settle = SN;
         else if (u_tick && m_settle > 0) m_settle--;
      end
   end

   // per-cycle comparison at the falling edge
   always @(negedge clk) begin
      bit e_hit;
      if (load_en) n_load++;
      if (cmp_on && !done) begin
         e_hit = !sync_n && (m_low >= SYN - 1);
         chk(int'(drdy_n), int'(!(m_state == 2 && sync_n)), "R3 drdy_n");
         chk(int'(load_en), int'(m_state == 1 && m_hold == S - 1 && sync_n), "R3 load_en");
         chk(int'(cnt), m_cnt, "R2 count");
         chk(int'(tick), int'(m_cnt == P - 1 && !e_hit), "R2 tick");
         chk(int'(valid), int'(m_settle == 0), "R10 out_valid");
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 20000);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   task automatic step;
      @(posedge clk); #1;
   endtask

   task automatic pulse_res;
      res_valid = 1'b1;
      step();
      res_valid = 1'b0;
   endtask

   initial begin
      int c0, l0;
      repeat (2) @(negedge clk);
      // R1 / R12 during reset
      chk(int'(drdy_n), 1, "R1 drdy_n in reset");
      chk(int'(load_en), 0, "R1 load_en in reset");
      chk(int'(cnt), 0, "R1 count in reset");
      chk(int'(valid), 0, "R12 out_valid in reset");
      step(); rst_n = 1'b1; cmp_on = 1'b1;
      @(negedge clk);
      chk(int'(drdy_n), 1, "R1 drdy_n after reset");
      chk(int'(tick), 0, "R1 tick after reset");
      step();

      // R3 high phase then load
      pulse_res();
      for (int i = 1; i <= S; i++) begin
         @(negedge clk);
         chk(int'(drdy_n), 1, "R3 high phase");
         chk(int'(load_en), int'(i == S), "R3 load position");
      end
      @(negedge clk);
      chk(int'(drdy_n), 0, "R3 low after load");
      chk(int'(valid), 0, "R12 not settled yet");

      // R4 stays low without transaction
      repeat (3 * P) @(negedge clk);
      chk(int'(drdy_n), 0, "R4 held low");

      // R6 result during read is discarded
      step(); busy = 1'b1;
      l0 = n_load;
      pulse_res();
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         chk(int'(drdy_n), 0, "R6 strobe unchanged");
      end
      chk(n_load - l0, 0, "R6 no load");

      // R5 transaction end
      step(); busy = 1'b0;
      @(negedge clk);
      chk(int'(drdy_n), 0, "R5 before end seen");
      @(negedge clk);
      chk(int'(drdy_n), 1, "R5 after end");

      // R7 second result during high phase
      step();
      l0 = n_load;
      pulse_res();
      repeat (4) step();
      pulse_res();
      repeat (40) @(negedge clk);
      chk(n_load - l0, 1, "R7 single load");

      // R8 sync during high phase cancels load
      step();
      l0 = n_load;
      pulse_res();
      repeat (3) step();
      sync_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(int'(drdy_n), 1, "R8 inhibit");
         chk(int'(load_en), 0, "R8 no load");
      end
      step(); sync_n = 1'b1;
      repeat (30) @(negedge clk);
      chk(n_load - l0, 0, "R8 load cancelled");
      chk(int'(drdy_n), 1, "R8 strobe idle");

      // R9 short sync keeps counting
      c0 = int'(cnt);
      step(); sync_n = 1'b0;
      repeat (SYN - 1) step();
      sync_n = 1'b1;
      @(negedge clk);
      chk(int'(cnt), (c0 + SYN) % P, "R9 short pulse");

      // R9 long sync clears and holds
      step(); sync_n = 1'b0;
      repeat (SYN + 13) step();
      @(negedge clk);
      chk(int'(cnt), 0, "R9 cleared");
      chk(int'(tick), 0, "R9 no tick while held");

      // R11 three periods after release
      step(); sync_n = 1'b1;
      repeat (3 * P) @(negedge clk);
      chk(int'(valid), 0, "R11 before third tick");
      @(negedge clk);
      chk(int'(valid), 1, "R11 after third tick");

      // R10 input change
      step(); chg = 1'b1;
      step(); chg = 1'b0;
      @(negedge clk);
      chk(int'(valid), 0, "R10 cleared by change");
      repeat (4 * P + 2) @(negedge clk);
      chk(int'(valid), 1, "R10 settled");

      repeat (5) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule